// File: doc/BRIEF.md
# Base-two pseudo-softmax unit

This block turns a set of signed class scores into approximate probabilities without any exponential or divider hardware. Softmax is taken in base two instead of base e. Each score is read as the exponent of a positive floating-point number whose mantissa is exactly 1.0. A binary tree of positive-only floating-point adders reduces these numbers to one floating-point sum. The probability of class i is then 2^(x_i − E) times 1/M, where E is the exponent of the sum and M its mantissa.

The reciprocal 1/M is computed once and shared by every class. It uses a two-segment piecewise-linear fit whose coefficients reduce to shifts and adds. The reciprocal lies in [0.5, 1), so it is renormalized by doubling and subtracting one from every output exponent. Each class gets a 17-bit unsigned float with no sign bit and no zero encoding. A tiny probability shows up only as a very negative exponent.

A host presents all scores in parallel with a one-cycle strobe. The scores are captured on that edge. The results are valid, flagged by `out_valid`, in the following cycle and remain stable until the next strobe.

Top module: `pow2_softmax`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0. The captured scores are cleared to 0, so every class field reads exponent −4 and fraction 160 until the first strobe.
- R2: `out_valid` is 1 in exactly the cycle following each clock edge at which `in_valid` was 1, and 0 otherwise. Back-to-back strobes keep it high and show each new vector's result in turn.
- R3: When `in_valid` is 0, `in_scores` is ignored and every bit of `out_probs` holds its value.
- R4: The sum is built pairwise in a binary tree. At each adder the smaller operand's mantissa {1,frac} is shifted right by the exponent gap, with truncation, and contributes nothing when the gap is 9 or more. A mantissa result of 2.0 or more increments the exponent and drops the lowest bit.
- R5: With the sum mantissa m = 1 + f/256, the reciprocal is y = 1.59375 − 0.625·m when f[7] = 0, and y = 1.125 − 0.3125·m when f[7] = 1. The output fraction is floor(256·(2y − 1)).
- R6: Class i's field is `out_probs[17*i+16 : 17*i]`, with the exponent in bits [16:8] as a 9-bit two's-complement value and the fraction in bits [7:0] under an implicit leading 1. Every class carries the same fraction.
- R7: Class i's exponent is x_i − E − 1, where E is the sum exponent. Each non-saturated output lies within 8% relative of 2^x_i / Σ 2^x_k.
- R8: An exponent below −256 is saturated to −256.
- R9: Every output exponent is at most −1. The decoded outputs of one vector sum to within 8% of 1.
- R10: Scores of 127 do not overflow. Two classes at 127, with all others at −128, give exponent −2 and fraction 240 for both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe for `in_scores` |
| in_scores | input | N*SW (80) | Signed scores, class i in bits [8*i+7 : 8*i] |
| out_valid | output | 1 | Results valid, one cycle after a strobe |
| out_probs | output | N*(EW+8) (170) | Per-class 17-bit float, layout as in R6 |

## Verification
Two functions can land in the same cycle: a new strobe can arrive while `out_valid` is already high for the previous vector. The capture then has to overwrite the held result exactly on that edge. The bench provokes this with back-to-back strobes, carrying a dominant-score vector and then a tied-top vector. It judges the result by checking that `out_valid` stays high and that each cycle shows its own vector's exact exponents and fraction. Saturation and the adder's flush rule also meet in single vectors, where extreme scores drive both at once. Those cases are judged against hand-computed exact fields, and the other vectors against a real-valued base-two softmax model.

// File: rtl/psm_pkg.sv
package psm_pkg;

    // Mantissa fraction width; the reciprocal coefficients are tied to it.
    localparam int MW = 8;
    // Working width of the reciprocal datapath (units of 2^-12).
    localparam int RW = 13;
    // Segment intercepts scaled by 2^12.
    localparam logic [RW-1:0] RCP_C_STEEP   = 13'd6528;
    localparam logic [RW-1:0] RCP_C_SHALLOW = 13'd4608;
    // 0.5 in units of 2^-12.
    localparam logic [RW-1:0] RCP_HALF      = 13'd2048;

    typedef enum logic {
        SEG_STEEP   = 1'b0,
        SEG_SHALLOW = 1'b1
    } rcp_seg_e;

endpackage

// File: rtl/psm_sum_tree.sv
module psm_sum_tree
    import psm_pkg::*;
#(
    parameter int N   = 10,
    parameter int SW  = 8,
    parameter int ESW = 13
) (
    input  logic [N*SW-1:0]        scores,
    output logic signed [ESW-1:0]  sum_exp,
    output logic [MW-1:0]          sum_frac
);

    localparam int NODES = 2 * N;

    // Heap-ordered tree: node i adds nodes 2i and 2i+1, leaves at N..2N-1.
    logic signed [ESW-1:0] node_e [1:NODES-1];
    logic [MW-1:0]         node_f [1:NODES-1];

    function automatic logic [ESW+MW-1:0] fp_add(
        input logic signed [ESW-1:0] ea,
        input logic [MW-1:0]         fa,
        input logic signed [ESW-1:0] eb,
        input logic [MW-1:0]         fb
    );
        logic signed [ESW-1:0] e_big, e_small;
        logic [MW-1:0]         f_big, f_small;
        logic [ESW-1:0]        gap;
        logic [MW:0]           m_small;
        logic [MW+1:0]         m_sum;
        logic signed [ESW-1:0] e_res;
        logic [MW-1:0]         f_res;
        if (ea >= eb) begin
            e_big = ea; f_big = fa; e_small = eb; f_small = fb;
        end else begin
            e_big = eb; f_big = fb; e_small = ea; f_small = fa;
        end
        gap = ESW'(e_big - e_small);
        if (gap > ESW'(MW))
            m_small = '0;
        else
            m_small = {1'b1, f_small} >> gap;
        m_sum = {2'b01, f_big} + {1'b0, m_small};
        if (m_sum[MW+1]) begin
            e_res = e_big + ESW'(1);
            f_res = m_sum[MW:1];
        end else begin
            e_res = e_big;
            f_res = m_sum[MW-1:0];
        end
        return {e_res, f_res};
    endfunction

    always_comb begin
        for (int k = 0; k < N; k++) begin
            node_e[N+k] = ESW'(signed'(scores[k*SW +: SW]));
            node_f[N+k] = '0;
        end
        for (int i = N - 1; i >= 1; i--) begin
            {node_e[i], node_f[i]} = fp_add(node_e[2*i], node_f[2*i],
                                            node_e[2*i+1], node_f[2*i+1]);
        end
        sum_exp  = node_e[1];
        sum_frac = node_f[1];
    end

endmodule

// File: rtl/psm_recip.sv
module psm_recip
    import psm_pkg::*;
(
    input  logic [MW-1:0] mant_frac,
    output logic [MW-1:0] rcp_frac
);

    rcp_seg_e       seg;
    logic [RW-1:0]  x_w;
    logic [RW-1:0]  y_w;

    always_comb begin
        seg = rcp_seg_e'(mant_frac[MW-1]);
        // Mantissa 1.f in units of 2^-8.
        x_w = RW'({1'b1, mant_frac});
        // Results in units of 2^-12.
        unique case (seg)
            SEG_STEEP:   y_w = RCP_C_STEEP   - (x_w << 3) - (x_w << 1);
            SEG_SHALLOW: y_w = RCP_C_SHALLOW - (x_w << 2) - x_w;
            default:     y_w = RCP_HALF;
        endcase
        // y in [0.5,1): fraction of 2y is (y - 0.5) * 2 in units of 2^-8.
        rcp_frac = MW'((y_w - RCP_HALF) >> 3);
    end

endmodule

// File: rtl/pow2_softmax.sv
module pow2_softmax
    import psm_pkg::*;
#(
    parameter int N  = 10,
    parameter int SW = 8,
    parameter int EW = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [N*SW-1:0]        in_scores,
    output logic                   out_valid,
    output logic [N*(EW+MW)-1:0]   out_probs
);

    localparam int ESW     = SW + $clog2(N) + 1;
    localparam int DW      = ESW + 1;
    localparam int OW      = EW + MW;
    localparam int EXP_MIN = -(1 << (EW - 1));

    typedef struct packed {
        logic            vld;
        logic [N*SW-1:0] scores;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid)
            st_d.scores = in_scores;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    logic signed [ESW-1:0] sum_exp;
    logic [MW-1:0]         sum_frac;
    logic [MW-1:0]         rcp_frac;

    psm_sum_tree #(.N(N), .SW(SW), .ESW(ESW)) u_tree (
        .scores   (st_q.scores),
        .sum_exp  (sum_exp),
        .sum_frac (sum_frac)
    );

    psm_recip u_recip (
        .mant_frac (sum_frac),
        .rcp_frac  (rcp_frac)
    );

    for (genvar k = 0; k < N; k++) begin : g_class
        logic signed [DW-1:0] diff_d;
        logic signed [EW-1:0] exp_d;
        always_comb begin
            diff_d = DW'(signed'(st_q.scores[k*SW +: SW])) - DW'(sum_exp) - DW'(1);
            if (int'(diff_d) < EXP_MIN)
                exp_d = EW'(EXP_MIN);
            else
                exp_d = diff_d[EW-1:0];
        end
        assign out_probs[k*OW +: OW] = {exp_d, rcp_frac};

        // R9: no output reaches 1.0
        a_r9_below_one: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> out_probs[k*OW + OW - 1]);
    end

    assign out_valid = st_q.vld;

    // R2: a strobe is answered in the next cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2: no strobe, no valid
    a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3: outputs hold without a strobe
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_probs));
    // R5: the shared reciprocal never exceeds 0.96875
    a_r5_recip_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (rcp_frac <= 8'd240));

endmodule

// File: tb/pow2_softmax_bench.sv
module pow2_softmax_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 10;
    localparam int SW = 8;
    localparam int OW = 17;
    localparam int WD_CYCLES = 20000;
    localparam int NV = 6;

    localparam int TV [0:NV-1][0:N-1] = '{
        '{   3,    1,    0,   -2,    5,    4,   -1,    2,    0,    1},
        '{ -10,  -12,   -9,  -20,  -11,  -30,  -15,   -9,   -8,  -40},
        '{ 100,   98,   99,   60,   97, -128,  101,   90,   95,   96},
        '{   0,    0,    0,    0,    0,    0,    0,    0,    0,    7},
        '{-128, -127, -126, -125, -124, -123, -122, -121, -120, -100},
        '{  20,   -5,    6,    7,   13,   19,   -3,    0,   11,   12}
    };
    localparam int TV_ARGMAX [0:NV-1] = '{4, 8, 6, 9, 9, 0};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [N*SW-1:0] in_scores = '0;
    logic            out_valid;
    logic [N*OW-1:0] out_probs;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    int sc [0:N-1];

    pow2_softmax u_pow2_softmax (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_scores (in_scores),
        .out_valid (out_valid),
        .out_probs (out_probs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_of(int k);
        logic signed [8:0] e;
        e = out_probs[k*OW+8 +: 9];
        return int'(e);
    endfunction

    function automatic int frac_of(int k);
        return int'(out_probs[k*OW +: 8]);
    endfunction

    function automatic real val_of(int k);
        return (1.0 + real'(frac_of(k)) / 256.0) * (2.0 ** real'(exp_of(k)));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic pack();
        for (int k = 0; k < N; k++) in_scores[k*SW +: SW] = SW'(sc[k]);
    endtask

    task automatic strobe();
        @(negedge clk);
        pack();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic fill(input int v);
        for (int k = 0; k < N; k++) sc[k] = v;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYCLES, 0);
            summary();
            $finish;
        end
    end

    initial begin : stim
        bit ok;
        int eexp;
        real s, p, tot;
        // Reset
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid during reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        ok = 1'b1;
        for (int k = 0; k < N; k++) if (exp_of(k) != -4 || frac_of(k) != 160) ok = 1'b0;
        chk(ok, "R1", "cleared state class0 exp", exp_of(0), -4);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < N; k++) sc[k] = TV[v][k];
            strobe();
            chk(out_valid == 1'b1, "R2", "out_valid after strobe", int'(out_valid), 1);
            s = 0.0;
            for (int k = 0; k < N; k++) s += 2.0 ** real'(sc[k]);
            ok = 1'b1;
            tot = 0.0;
            for (int k = 0; k < N; k++) begin
                p = (2.0 ** real'(sc[k])) / s;
                tot += val_of(k);
                if (val_of(k) > p * 1.08 || val_of(k) < p * 0.92) begin
                    ok = 1'b0;
                    $display("  vector %0d class %0d got %g want %g", v, k, val_of(k), p);
                end
            end
            chk(ok, "R7", "per-class accuracy vector", v, v);
            chk(tot > 0.92 && tot < 1.08, "R9", "sum of outputs x1000",
                int'(tot * 1000.0), 1000);
            ok = 1'b1;
            for (int k = 1; k < N; k++) if (frac_of(k) != frac_of(0)) ok = 1'b0;
            chk(ok, "R6", "shared fraction", frac_of(N-1), frac_of(0));
            ok = 1'b1;
            for (int k = 0; k < N; k++)
                if (exp_of(k) > exp_of(TV_ARGMAX[v]) || exp_of(k) > -1) ok = 1'b0;
            chk(ok, "R9", "argmax exponent", exp_of(TV_ARGMAX[v]), -1);
            @(negedge clk);
            chk(out_valid == 1'b0, "R2", "out_valid drops", int'(out_valid), 0);
        end

        // Shallow segment: three scores 0, sum 3 = 1.5 * 2^1
        fill(-128); sc[0] = 0; sc[1] = 0; sc[2] = 0;
        strobe();
        chk(frac_of(0) == 80, "R5", "shallow-segment fraction", frac_of(0), 80);
        chk(exp_of(1) == -2, "R7", "exponent x=0 E=1", exp_of(1), -2);
        chk(exp_of(5) == -130, "R7", "exponent x=-128 E=1", exp_of(5), -130);

        // Flush boundary: gap 9 discarded, gap 8 kept
        fill(-128); sc[0] = 0; sc[1] = -9;
        strobe();
        chk(frac_of(0) == 240, "R4", "gap 9 flushed fraction", frac_of(0), 240);
        fill(-128); sc[0] = 0; sc[1] = -8;
        strobe();
        chk(frac_of(0) == 238, "R4", "gap 8 kept fraction", frac_of(0), 238);

        // Carry renormalization: 2 + 1 + 1 = 4
        fill(-128); sc[0] = 1; sc[1] = 0; sc[2] = 0;
        strobe();
        chk(exp_of(0) == -2 && frac_of(0) == 240, "R4", "carry exponent class0",
            exp_of(0), -2);

        // Back-to-back strobes: dominant 127, then two tied at 127
        @(negedge clk);
        fill(-128); sc[3] = 127;
        pack();
        in_valid = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b1, "R2", "first of back-to-back", int'(out_valid), 1);
        chk(exp_of(3) == -1 && frac_of(3) == 240, "R7", "dominant exponent",
            exp_of(3), -1);
        chk(exp_of(0) == -256, "R7", "loser exponent at limit", exp_of(0), -256);
        fill(-128); sc[3] = 127; sc[7] = 127;
        pack();
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R2", "second of back-to-back", int'(out_valid), 1);
        chk(exp_of(3) == -2 && exp_of(7) == -2 && frac_of(7) == 240, "R10",
            "tied 127 exponent", exp_of(7), -2);
        chk(exp_of(0) == -256, "R8", "saturated exponent", exp_of(0), -256);

        // Hold: scores change without strobe
        @(negedge clk);
        fill(5); sc[2] = 60;
        pack();
        repeat (2) @(negedge clk);
        chk(exp_of(3) == -2 && exp_of(0) == -256 && out_valid == 1'b0, "R3",
            "ignored scores class3 exp", exp_of(3), -2);

        // Reset clears captured scores again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        eexp = exp_of(2);
        chk(eexp == -4 && frac_of(2) == 160 && out_valid == 1'b0, "R1",
            "re-reset class2 exp", eexp, -4);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule